// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a register-mapped timer with two personalities chosen by a mode bit. A prescaler divides the core clock into a count tick. In system mode the tick count is kept inside a programmable period. Each time the count wraps, a sticky reached flag is set and a level interrupt is raised. Software acknowledges the interrupt by reading back the limit. In user mode the same counter runs freely as a 54-bit value. Software can halt and resume it, and it reads the value back as a high word and a low word.

The count always appears with its least significant tick at bit 9 of the data word, so a limit value is written in the same units as the count read back. The bus is a plain word-addressed port with separate read and write strobes. Read data is registered.

Top module: `lim_timer`

## Requirements
- R1: With parameter CLK_DIV = D, the counter advances by one exactly once every D enabled clock cycles, counted from the last restart. In every count read, the tick count is placed with its LSB at bit 9, and bits 8..0 read as zero.
- R2: In system mode the period P is limit[30:9]. A stored limit of 0 gives P = 0x3FFFFF, and a nonzero limit with bits 30..9 all zero gives P = 1. The count steps 0, 1, ... and returns to 0 on the tick that would reach P.
- R3: A write to index 0 or index 2 stores the limit. A data value of 0 is stored as 0x7FFFFFFF, and any other value has bit 31 cleared. Index 0 also restarts the count and the prescaler from zero. Index 2 leaves both running.
- R4: In system mode, an index 1 read returns the reached flag in bit 31 and the count in bits 30..9.
- R5: A wrap in system mode sets the reached flag and drives irq high. Both stay set until the acknowledging read.
- R6: In system mode, an index 0 read returns the stored limit. The same read clears the flag and irq and restarts the count and the prescaler.
- R7: Index 3 bit 0 takes effect only in user mode. Writing 1 freezes both the counter and the prescaler. Writing 0 resumes counting from the frozen value. An index 3 read returns the stopped bit in bit 0, and writes to index 3 in system mode leave that bit unchanged.
- R8: In user mode the counter is a 54-bit free-running value. An index 1 read returns count bits 22..0 placed at bits 31..9. An index 0 read returns count bits 53..23 in bits 30..0, with bit 31 zero. Neither read has any side effect.
- R9: Index 4 bit 0 selects user mode (1) or system mode (0), and reads back in bit 0. While in user mode irq is low, but the flag is kept, so irq returns when system mode is selected again.
- R10: After reset the block is in system mode with limit 0, count 0, the flag clear and the stopped bit set.
- R11: The register index is bus_addr[4:2], and bus_addr[1:0] are ignored. Indices 5 to 7 read as zero, and writes to them change nothing.
- R12: bus_rdata presents the read value on the clock edge that samples bus_rd, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address, index in bits 4..2 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, system mode only |

## Verification
The bench builds the timer with CLK_DIV = 4, so a tick takes four cycles. At that rate, periods of one to five ticks can be swept at every cycle offset within two full wraps. Every offset of the prescaler phase is covered against the reached flag and against irq. The small divider also keeps the user-mode stop and resume arithmetic short, including a freeze in the middle of a prescaler phase. The user high word is checked only at zero, because it would take 2^23 ticks to reach.

// File: rtl/limtmr_pkg.sv
package limtmr_pkg;

    localparam int TICK_LSB = 9;
    localparam int SYS_W    = 22;
    localparam int USR_W    = 54;
    localparam int LO_W     = 32 - TICK_LSB;
    localparam logic [30:0] LIMIT_FULL = 31'h7FFF_FFFF;

    typedef enum logic [2:0] {
        IX_LIM_RESTART = 3'd0,
        IX_COUNT       = 3'd1,
        IX_LIM_KEEP    = 3'd2,
        IX_RUNCTL      = 3'd3,
        IX_MODE        = 3'd4
    } reg_ix_e;

    typedef struct packed {
        logic restart;
        logic run;
        logic user;
    } cnt_ctl_t;

    function automatic logic [30:0] limit_norm(input logic [31:0] v);
        return (v == 32'd0) ? LIMIT_FULL : v[30:0];
    endfunction

    function automatic logic [SYS_W-1:0] sys_period(input logic [30:0] lim);
        logic [SYS_W-1:0] p;
        p = (lim == 31'd0) ? {SYS_W{1'b1}} : lim[30:TICK_LSB];
        return (p == '0) ? SYS_W'(1) : p;
    endfunction

endpackage

// File: rtl/limtmr_prescale.sv
module limtmr_prescale #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + PW'(1);
        end
    end

    assign tick = run && (phase == LAST);
endmodule

// File: rtl/limtmr_counter.sv
module limtmr_counter
    import limtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             user,
    input  logic             tick,
    input  logic [SYS_W-1:0] period,
    output logic [USR_W-1:0] cnt,
    output logic             wrap
);
    logic [SYS_W:0] sys_next;

    assign sys_next = {1'b0, cnt[SYS_W-1:0]} + (SYS_W+1)'(1);
    assign wrap = tick && !user && !restart && (sys_next >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (user)
                cnt <= cnt + USR_W'(1);
            else if (wrap)
                cnt <= '0;
            else
                cnt <= {{(USR_W-SYS_W){1'b0}}, sys_next[SYS_W-1:0]};
        end
    end
endmodule

// File: rtl/limtmr_regs.sv
module limtmr_regs
    import limtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ix,
    input  logic             wr,
    input  logic             rd,
    input  logic [31:0]      wdata,
    input  logic [USR_W-1:0] cnt,
    input  logic             wrap,
    output cnt_ctl_t         ctl,
    output logic [SYS_W-1:0] period,
    output logic [31:0]      rdata,
    output logic             irq
);
    logic [30:0] limit_q;
    logic        user_q;
    logic        stopped_q;
    logic        flag_q;
    logic        ack;
    logic        wr_limit;
    logic [31:0] rd_val;

    assign wr_limit = wr && (ix == IX_LIM_RESTART || ix == IX_LIM_KEEP);
    assign ack      = rd && (ix == IX_LIM_RESTART) && !user_q;

    assign ctl.restart = (wr && ix == IX_LIM_RESTART) || ack;
    assign ctl.run     = !(user_q && stopped_q);
    assign ctl.user    = user_q;
    assign period      = sys_period(limit_q);
    assign irq         = flag_q && !user_q;

    always_comb begin
        case (ix)
            IX_LIM_RESTART: rd_val = user_q ? {1'b0, cnt[USR_W-1:LO_W]}
                                            : {1'b0, limit_q};
            IX_COUNT:       rd_val = user_q ? {cnt[LO_W-1:0], {TICK_LSB{1'b0}}}
                                            : {flag_q, cnt[SYS_W-1:0], {TICK_LSB{1'b0}}};
            IX_RUNCTL:      rd_val = {31'd0, stopped_q};
            IX_MODE:        rd_val = {31'd0, user_q};
            default:        rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q   <= '0;
            user_q    <= 1'b0;
            stopped_q <= 1'b1;
            flag_q    <= 1'b0;
            rdata     <= '0;
        end else begin
            if (wr_limit)
                limit_q <= limit_norm(wdata);
            if (wr && ix == IX_RUNCTL && user_q)
                stopped_q <= wdata[0];
            if (wr && ix == IX_MODE)
                user_q <= wdata[0];
            if (ack)
                flag_q <= 1'b0;
            else if (wrap)
                flag_q <= 1'b1;
            if (rd)
                rdata <= rd_val;
        end
    end
endmodule

// File: rtl/lim_timer.sv
module lim_timer
    import limtmr_pkg::*;
#(
    parameter int CLK_DIV = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    cnt_ctl_t         ctl;
    logic             tick;
    logic             wrap;
    logic [SYS_W-1:0] period;
    logic [USR_W-1:0] cnt;
    logic             unused_byte_lanes;

    assign unused_byte_lanes = ^bus_addr[1:0];

    limtmr_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.restart),
        .run     (ctl.run),
        .tick    (tick)
    );

    limtmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.restart),
        .user    (ctl.user),
        .tick    (tick),
        .period  (period),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    limtmr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .ix     (bus_addr[4:2]),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .wrap   (wrap),
        .ctl    (ctl),
        .period (period),
        .rdata  (bus_rdata),
        .irq    (irq)
    );
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk
    import limtmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input cnt_ctl_t         ctl,
    input logic [USR_W-1:0] cnt
);
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rd) && $past(bus_addr[4:2]) == 3'd1) |-> (bus_rdata[8:0] == 9'd0));

    a_r5_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_rd && bus_addr[4:2] == 3'd0) && !(bus_wr && bus_addr[4:2] == 3'd4))
        |=> irq);

    a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[4:2] == 3'd0 && !ctl.user) |=> !irq);

    a_r7_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !ctl.restart) |=> $stable(cnt));

    a_r9_user_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[4:2] == 3'd4 && bus_wdata[0]) |=> !irq);
endmodule

bind lim_timer lim_timer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctl       (ctl),
    .cnt       (cnt)
);

// File: tb/lim_timer_tb_top.sv
module lim_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lim_timer #(.CLK_DIV(D)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ix, input logic [31:0] d, input logic [1:0] lo = 2'b00);
        bus_addr = {ix[2:0], lo};
        bus_wdata = d;
        bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ix, output logic [31:0] d, input logic [1:0] lo = 2'b00);
        bus_addr = {ix[2:0], lo};
        bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int t;
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk({31'd0, irq}, 32'd0, "R10 irq after reset");
        rd(3, v); chk(v, 32'd1, "R10 stopped after reset");
        rd(4, v); chk(v, 32'd0, "R10 mode after reset");
        rd(0, v); chk(v, 32'd0, "R10 limit after reset");
        rd(1, v); chk(v, 32'd0, "R10 count right after restart");

        // R7 run control ignored in system mode
        wr(3, 32'd0);
        rd(3, v); chk(v, 32'd1, "R7 runctl ignored in system mode");

        // R2 R4 R5 R1: sweep period and every cycle offset
        for (int p = 1; p <= 5; p++) begin
            for (int g = 0; g <= (2 * p + 1) * D; g++) begin
                wr(0, p << 9);
                idle(g);
                rd(1, v);
                t = g / D;
                chk(v, {(t >= p) ? 1'b1 : 1'b0, 22'(t % p), 9'd0}, "R2 R4 count and reached");
                chk({31'd0, irq}, {31'd0, ((g + 1) / D) >= p}, "R5 irq level");
                rd(0, v);
                chk({31'd0, irq}, 32'd0, "R6 irq cleared by limit read");
            end
        end

        // R6 acknowledge returns limit and restarts count
        wr(0, 32'h0000_0600);
        idle(3 * D + 2);
        chk({31'd0, irq}, 32'd1, "R5 irq raised at wrap");
        idle(5);
        chk({31'd0, irq}, 32'd1, "R5 irq held");
        rd(0, v); chk(v, 32'h0000_0600, "R6 limit read value");
        chk({31'd0, irq}, 32'd0, "R6 irq after ack");
        rd(1, v); chk(v, 32'd0, "R6 count and flag restarted");

        // R3 index 2 keeps count
        wr(0, 32'd10 << 9);
        idle(5 * D);
        wr(2, 32'd20 << 9);
        idle(3 * D - 1);
        rd(1, v); chk(v, 32'd8 << 9, "R3 index 2 keeps running count");
        wr(0, 32'd20 << 9);
        idle(D - 1);
        rd(1, v); chk(v, 32'd0, "R3 index 0 restarts count");

        // R3 limit normalisation
        wr(2, 32'd0);
        rd(0, v); chk(v, 32'h7FFF_FFFF, "R3 zero limit stored as max");
        wr(2, 32'hFFFF_FFFF);
        rd(0, v); chk(v, 32'h7FFF_FFFF, "R3 bit 31 cleared");
        wr(2, 32'h8000_1234, 2'b11);
        rd(0, v, 2'b10); chk(v, 32'h0000_1234, "R3 R11 masked limit, low addr bits ignored");

        // R2 small limit gives period one
        wr(0, 32'h0000_01FF);
        idle(D);
        rd(1, v); chk(v, 32'h8000_0000, "R2 period one wraps every tick");

        // R11 unused indices
        wr(0, 32'h0000_0A00);
        wr(5, 32'hFFFF_FFFF);
        wr(6, 32'h1234_5678);
        wr(7, 32'd1);
        rd(5, v); chk(v, 32'd0, "R11 index 5 reads zero");
        rd(6, v); chk(v, 32'd0, "R11 index 6 reads zero");
        rd(7, v); chk(v, 32'd0, "R11 index 7 reads zero");
        rd(4, v); chk(v, 32'd0, "R11 mode untouched by index 7");
        rd(0, v); chk(v, 32'h0000_0A00, "R11 limit untouched");

        // R12 read data holds between reads
        idle(7);
        chk(bus_rdata, 32'h0000_0A00, "R12 read data held");

        // R9 user mode hides irq, flag kept
        wr(0, 32'h0000_0200);
        idle(D);
        chk({31'd0, irq}, 32'd1, "R5 irq before mode switch");
        wr(4, 32'd1);
        chk({31'd0, irq}, 32'd0, "R9 irq low in user mode");
        rd(4, v); chk(v, 32'd1, "R9 mode reads back");

        // R7 R8 user counter, stopped from reset
        wr(0, 32'd0);
        idle(3 * D);
        rd(1, v); chk(v, 32'd0, "R7 counter frozen while stopped");
        rd(3, v); chk(v, 32'd1, "R7 stopped status");
        wr(3, 32'd0);
        idle(10 * D + 2);
        wr(3, 32'd1);
        s = 10 * D + 3;
        idle(20);
        rd(1, v); chk(v, (s / D) << 9, "R7 R8 frozen value after stop");
        rd(3, v); chk(v, 32'd1, "R7 stop status reads one");
        wr(3, 32'd0);
        idle(7);
        rd(1, v); chk(v, ((s + 7) / D) << 9, "R7 resume from frozen phase");
        rd(0, v); chk(v, 32'd0, "R8 high word");
        rd(3, v); chk(v, 32'd0, "R7 running status");
        chk({31'd0, irq}, 32'd0, "R8 user reads leave irq hidden");

        // R9 back to system mode, flag still present
        wr(4, 32'd0);
        chk({31'd0, irq}, 32'd1, "R9 irq returns in system mode");
        rd(0, v);
        chk({31'd0, irq}, 32'd0, "R6 ack after mode return");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule